// File: doc/BRIEF.md
# Wait-State External Memory Bridge

This block connects a simple word-wide CPU request port to an asynchronous external memory bus with eight active-low chip selects. Flash, pseudo-SRAM, peripherals and internal fast memories each sit behind a chip select. Address bits [26:24] pick the chip select. Every chip select has its own 16-bit setup register. That register sets the wait-state count, the external data width, whether writes reach the device, and whether an idle gap follows each access.

A CPU access is a single-cycle `cpu_req` pulse, accepted while `cpu_rdy` is high. The bridge copies the address, the data and the setup of the selected chip select into registers. If the external port is narrower than 32 bits, the access becomes several sub-cycles, lowest address first. Each sub-cycle holds the chip select low for WS+1 clocks. `cpu_rdy` returns high once the access is finished, and read data is valid at that point. Boot code can run straight out of reset, because every chip select starts with the slowest timing.

Top module: `extmem_ws_bridge`

## Requirements
- R1: After reset, `cpu_rdy` is 1, all `ext_cs_n` bits are 1, and every setup register reads 0x02BF (WS=31, 16-bit, writes on, gap on).
- R2: Setup register layout: bits [4:0] WS, bits [6:5] width (00 = 8, 01 = 16, 10 and 11 = 32 bits), bit 7 write enable, bit 9 gap enable. Other bits read 0. `cfg_rdata` shows the register at `cfg_idx` one clock later.
- R3: During an access exactly one `ext_cs_n` bit is low. Its index is `cpu_addr[26:24]`.
- R4: Each sub-cycle keeps the chip select low for exactly WS+1 clocks. WS=0 gives a single clock.
- R5: An 8-bit port gives 4 sub-cycles and a 16-bit port gives 2. `ext_addr` is the word address plus 0,1,2,3 or 0,2 respectively, in ascending order. Data uses the low lanes of the external bus.
- R6: The read data of sub-cycle k fills CPU bits [k*w +: w], where w is the port width. It is captured on the last clock of that sub-cycle.
- R7: During a write sub-cycle, `ext_we_n` is low for all of its clocks if the write-enable bit is set. If the bit is clear, `ext_we_n` stays high and the access still takes the same time.
- R8: `cpu_rdy` falls the clock after a request is accepted. Requests made while `cpu_rdy` is low are ignored.
- R9: With the gap enabled, one clock with every chip select high and `cpu_rdy` low follows the last sub-cycle. With the gap disabled, `cpu_rdy` rises right after the last sub-cycle.
- R10: An access uses the setup captured when it is accepted. A setup write in the same clock takes effect from the next access.
- R11: `ext_oe_n` is low during every clock of a read sub-cycle and high for writes and when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request pulse, taken when `cpu_rdy` is high |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address, word aligned |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Assembled read data |
| cpu_rdy | output | 1 | High when idle and after completion |
| cfg_we | input | 1 | Setup register write strobe |
| cfg_idx | input | 3 | Setup register index (halfword offset) |
| cfg_wdata | input | 16 | Setup write value |
| cfg_rdata | output | 16 | Registered setup readback |
| ext_cs_n | output | 8 | Active-low chip selects |
| ext_addr | output | 24 | External byte address |
| ext_wdata | output | 32 | External write data, low lanes used |
| ext_rdata | input | 32 | External read data |
| ext_oe_n | output | 1 | Active-low output enable |
| ext_we_n | output | 1 | Active-low write strobe |

## Verification
Two events can coincide. A setup register may be rewritten in the same clock that a request to the same chip select is accepted, and a new request may arrive while an access is still running. The bench raises `cfg_we` and `cpu_req` together and checks that the first access keeps the old wait count while the next one uses the new value. It also pulses a request to a different chip select in the middle of a transfer, then checks that the selected line never changes and that the bus stays idle afterwards.

// File: rtl/extmem_pkg.sv
package extmem_pkg;
  localparam int WS_W  = 5;
  localparam int CFG_W = 16;
  localparam logic [1:0] W8  = 2'b00;
  localparam logic [1:0] W16 = 2'b01;

  typedef struct packed {
    logic            gap;
    logic            wr_en;
    logic [1:0]      width;
    logic [WS_W-1:0] ws;
  } cs_cfg_t;

  localparam logic [CFG_W-1:0] CFG_RST = 16'h02BF;

  function automatic cs_cfg_t cfg_unpack(input logic [CFG_W-1:0] v);
    cs_cfg_t c;
    c.ws    = v[4:0];
    c.width = v[6:5];
    c.wr_en = v[7];
    c.gap   = v[9];
    return c;
  endfunction

  function automatic logic [CFG_W-1:0] cfg_pack(input cs_cfg_t c);
    return {6'b0, c.gap, 1'b0, c.wr_en, c.width, c.ws};
  endfunction
endpackage

// File: rtl/extmem_cfg_regs.sv
module extmem_cfg_regs
  import extmem_pkg::*;
#(
  parameter int NUM_CS = 8,
  localparam int IDX_W = $clog2(NUM_CS)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr,
  input  logic [IDX_W-1:0]             idx,
  input  logic [CFG_W-1:0]             wdata,
  output logic [CFG_W-1:0]             rdata,
  output cs_cfg_t [NUM_CS-1:0]         cfg_all
);
  for (genvar g = 0; g < NUM_CS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        cfg_all[g] <= cfg_unpack(CFG_RST);
      else if (wr && idx == IDX_W'(g))
        cfg_all[g] <= cfg_unpack(wdata);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= CFG_RST;
    else     rdata <= cfg_pack(cfg_all[idx]);
  end
endmodule

// File: rtl/extmem_cs_decode.sv
module extmem_cs_decode #(
  parameter int NUM_CS = 8,
  localparam int IDX_W = $clog2(NUM_CS)
) (
  input  logic              active,
  input  logic [IDX_W-1:0]  sel,
  output logic [NUM_CS-1:0] cs_n
);
  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_n[g] = !(active && sel == IDX_W'(g));
  end
endmodule

// File: rtl/extmem_seq.sv
module extmem_seq
  import extmem_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int DATA_W = 32,
  parameter int EXT_AW = 24,
  localparam int IDX_W = $clog2(NUM_CS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req,
  input  logic                 we,
  input  logic [IDX_W-1:0]     cs_idx,
  input  logic [EXT_AW-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  input  cs_cfg_t [NUM_CS-1:0] cfg_all,
  input  logic [DATA_W-1:0]    ext_rdata,
  output logic                 rdy,
  output logic [DATA_W-1:0]    rdata,
  output logic                 xfer,
  output logic [IDX_W-1:0]     cs_sel,
  output logic [EXT_AW-1:0]    ext_addr,
  output logic [DATA_W-1:0]    ext_wdata,
  output logic                 oe_n,
  output logic                 we_n
);
  typedef enum logic [1:0] {S_IDLE, S_XFER, S_GAP} st_t;

  st_t              st;
  logic [WS_W-1:0]  cnt;
  logic [1:0]       beat;
  logic [1:0]       off;
  logic [4:0]       shamt;
  logic             last_beat;
  cs_cfg_t          cfg_q;
  logic             we_q;
  logic [EXT_AW-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  always_comb begin
    case (cfg_q.width)
      W8:      begin off = beat;            last_beat = (beat == 2'd3); end
      W16:     begin off = {beat[0], 1'b0}; last_beat = (beat == 2'd1); end
      default: begin off = 2'd0;            last_beat = 1'b1;          end
    endcase
    shamt = {off, 3'b000};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      rdy     <= 1'b1;
      cnt     <= '0;
      beat    <= '0;
      cs_sel  <= '0;
      cfg_q   <= cfg_unpack(CFG_RST);
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata   <= '0;
    end else begin
      case (st)
        S_IDLE: if (req) begin
          st      <= S_XFER;
          rdy     <= 1'b0;
          cnt     <= '0;
          beat    <= '0;
          cs_sel  <= cs_idx;
          cfg_q   <= cfg_all[cs_idx];
          we_q    <= we;
          addr_q  <= {addr[EXT_AW-1:2], 2'b00};
          wdata_q <= wdata;
        end
        S_XFER: if (cnt == cfg_q.ws) begin
          if (!we_q) begin
            case (cfg_q.width)
              W8:      rdata[{beat, 3'b000} +: 8]     <= ext_rdata[7:0];
              W16:     rdata[{beat[0], 4'b0000} +: 16] <= ext_rdata[15:0];
              default: rdata <= ext_rdata;
            endcase
          end
          cnt <= '0;
          if (last_beat) begin
            st  <= cfg_q.gap ? S_GAP : S_IDLE;
            rdy <= !cfg_q.gap;
          end else begin
            beat <= beat + 2'd1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: begin
          st  <= S_IDLE;
          rdy <= 1'b1;
        end
      endcase
    end
  end

  assign xfer      = (st == S_XFER);
  assign ext_addr  = {addr_q[EXT_AW-1:2], off};
  assign ext_wdata = wdata_q >> shamt;
  assign oe_n      = !(xfer && !we_q);
  assign we_n      = !(xfer && we_q && cfg_q.wr_en);
endmodule

// File: rtl/extmem_ws_bridge.sv
module extmem_ws_bridge
  import extmem_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int EXT_AW = 24,
  parameter int CS_LSB = 24,
  localparam int IDX_W = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_rdy,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [15:0]       cfg_wdata,
  output logic [15:0]       cfg_rdata,
  output logic [NUM_CS-1:0] ext_cs_n,
  output logic [EXT_AW-1:0] ext_addr,
  output logic [DATA_W-1:0] ext_wdata,
  input  logic [DATA_W-1:0] ext_rdata,
  output logic              ext_oe_n,
  output logic              ext_we_n
);
  cs_cfg_t [NUM_CS-1:0] cfg_all;
  logic                 xfer;
  logic [IDX_W-1:0]     cs_sel;

  extmem_cfg_regs #(.NUM_CS(NUM_CS)) u_regs (
    .clk(clk), .rst(rst), .wr(cfg_we), .idx(cfg_idx),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .cfg_all(cfg_all)
  );

  extmem_seq #(.NUM_CS(NUM_CS), .DATA_W(DATA_W), .EXT_AW(EXT_AW)) u_seq (
    .clk(clk), .rst(rst), .req(cpu_req), .we(cpu_we),
    .cs_idx(cpu_addr[CS_LSB +: IDX_W]), .addr(cpu_addr[EXT_AW-1:0]),
    .wdata(cpu_wdata), .cfg_all(cfg_all), .ext_rdata(ext_rdata),
    .rdy(cpu_rdy), .rdata(cpu_rdata), .xfer(xfer), .cs_sel(cs_sel),
    .ext_addr(ext_addr), .ext_wdata(ext_wdata), .oe_n(ext_oe_n), .we_n(ext_we_n)
  );

  extmem_cs_decode #(.NUM_CS(NUM_CS)) u_dec (
    .active(xfer), .sel(cs_sel), .cs_n(ext_cs_n)
  );
endmodule

// File: rtl/extmem_ws_bridge_chk.sv
module extmem_ws_bridge_chk #(
  parameter int NUM_CS = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_req,
  input logic              cpu_rdy,
  input logic [NUM_CS-1:0] ext_cs_n,
  input logic              ext_oe_n,
  input logic              ext_we_n
);
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cpu_rdy && (&ext_cs_n)));
  a_r3_one_cs: assert property (@(posedge clk) disable iff (rst)
    $countones(~ext_cs_n) <= 1);
  a_r8_busy_on_accept: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && cpu_rdy) |=> !cpu_rdy);
  a_r8_cs_means_busy: assert property (@(posedge clk) disable iff (rst)
    !(&ext_cs_n) |-> !cpu_rdy);
  a_r11_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(!ext_oe_n && !ext_we_n));
  a_r7_strobe_in_cs: assert property (@(posedge clk) disable iff (rst)
    (!ext_oe_n || !ext_we_n) |-> !(&ext_cs_n));
endmodule

bind extmem_ws_bridge extmem_ws_bridge_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_rdy(cpu_rdy),
  .ext_cs_n(ext_cs_n), .ext_oe_n(ext_oe_n), .ext_we_n(ext_we_n)
);

// File: tb/extmem_ws_bridge_tb.sv
module extmem_ws_bridge_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_rdy;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [15:0] cfg_wdata = '0, cfg_rdata;
  logic [7:0]  ext_cs_n;
  logic [23:0] ext_addr;
  logic [31:0] ext_wdata, ext_rdata;
  logic        ext_oe_n, ext_we_n;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  extmem_ws_bridge u_dut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_rdy(cpu_rdy), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ext_cs_n(ext_cs_n),
    .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
    .ext_oe_n(ext_oe_n), .ext_we_n(ext_we_n)
  );

  function automatic logic [7:0] fb(input logic [23:0] a);
    return (a[7:0] ^ 8'hA5) + a[15:8];
  endfunction

  always_comb ext_rdata = {fb(ext_addr + 24'd3), fb(ext_addr + 24'd2),
                           fb(ext_addr + 24'd1), fb(ext_addr)};

  function automatic logic [15:0] mk(input int ws, input int wc, input bit wen, input bit gap);
    return 16'((gap ? 16'h0200 : 16'h0) | (wen ? 16'h0080 : 16'h0) | (wc << 5) | ws);
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic cfg_write(input int idx, input logic [15:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input int idx, output logic [15:0] v);
    @(negedge clk);
    cfg_idx = 3'(idx);
    @(negedge clk);
    v = cfg_rdata;
  endtask

  // One CPU access with full observation of the external bus.
  task automatic run_access(input logic [31:0] addr, input bit we, input logic [31:0] wd,
                            input int ws, input int nb, input bit gap, input bit wen,
                            input bit poke, input bit cfg_poke, input logic [15:0] cfg_v,
                            input string tag);
    int beats = 4 / nb;
    int cs = int'(addr[26:24]);
    logic [23:0] base = {addr[23:2], 2'b00};
    logic [23:0] last_a = 24'hFFFFFF;
    logic [7:0] wbytes [4];
    logic [31:0] exp_rd;
    int active = 0, total = 0, subs = 0, oe_cyc = 0, we_cyc = 0;
    bit cs_ok = 1, order_ok = 1, gap_ok = 1;
    for (int i = 0; i < 4; i++) wbytes[i] = 8'h00;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
    if (cfg_poke) begin cfg_we = 1'b1; cfg_idx = 3'(cs); cfg_wdata = cfg_v; end
    @(negedge clk);
    cpu_req = 1'b0; cfg_we = 1'b0;
    for (int n = 0; n < 400; n++) begin
      if (cpu_rdy) break;
      total++;
      if (ext_cs_n != 8'hFF) begin
        active++;
        if (ext_cs_n != ~(8'h01 << cs)) cs_ok = 0;
        if (ext_addr != last_a) begin
          if (ext_addr != base + 24'(subs * nb)) order_ok = 0;
          subs++;
          last_a = ext_addr;
        end
        if (!ext_oe_n) oe_cyc++;
        if (!ext_we_n) begin
          we_cyc++;
          for (int i = 0; i < nb; i++)
            wbytes[int'(ext_addr - base) + i] = ext_wdata[8*i +: 8];
        end
      end else if (active != beats * (ws + 1)) gap_ok = 0;
      if (poke && n == 2) begin
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = {5'b0, 3'(cs + 1), 24'h000040};
      end else cpu_req = 1'b0;
      @(negedge clk);
    end
    cpu_req = 1'b0;
    chk(cpu_rdy == 1'b1, "R8", {tag, " ready returns"}, cpu_rdy, 1);
    chk(cs_ok, "R3", {tag, " single chip select"}, cs_ok, 1);
    chk(active == beats * (ws + 1), "R4", {tag, " select clocks"}, active, beats * (ws + 1));
    chk(subs == beats && order_ok, "R5", {tag, " sub-cycle order"}, subs, beats);
    chk(total == active + (gap ? 1 : 0) && gap_ok, "R9", {tag, " gap clocks"},
        total - active, gap ? 1 : 0);
    if (!we) begin
      exp_rd = {fb(base + 24'd3), fb(base + 24'd2), fb(base + 24'd1), fb(base)};
      chk(cpu_rdata == exp_rd, "R6", {tag, " read data"}, cpu_rdata, exp_rd);
      chk(oe_cyc == active && we_cyc == 0, "R11", {tag, " oe clocks"}, oe_cyc, active);
    end else begin
      chk(oe_cyc == 0, "R11", {tag, " no oe on write"}, oe_cyc, 0);
      if (wen) begin
        chk(we_cyc == active, "R7", {tag, " we clocks"}, we_cyc, active);
        chk({wbytes[3], wbytes[2], wbytes[1], wbytes[0]} == wd, "R7", {tag, " write lanes"},
            {wbytes[3], wbytes[2], wbytes[1], wbytes[0]}, wd);
      end else begin
        chk(we_cyc == 0, "R7", {tag, " strobe suppressed"}, we_cyc, 0);
      end
    end
    if (poke) begin
      bit idle_ok = 1;
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        if (ext_cs_n != 8'hFF || !cpu_rdy) idle_ok = 0;
      end
      chk(idle_ok, "R8", {tag, " busy request ignored"}, idle_ok, 1);
    end
  endtask

  task automatic t_reset;
    logic [15:0] v;
    chk(cpu_rdy == 1'b1, "R1", "ready after reset", cpu_rdy, 1);
    chk(ext_cs_n == 8'hFF, "R1", "selects after reset", ext_cs_n, 8'hFF);
    for (int i = 0; i < 8; i++) begin
      cfg_read(i, v);
      chk(v == 16'h02BF, "R1", $sformatf("reset setup %0d", i), v, 16'h02BF);
    end
  endtask

  task automatic t_cfg_rw;
    logic [15:0] v;
    cfg_write(5, 16'hFFFF);
    cfg_read(5, v);
    chk(v == 16'h02FF, "R2", "unused bits read zero", v, 16'h02FF);
    cfg_write(0, 16'h02A1);
    cfg_read(0, v);
    chk(v == 16'h02A1, "R2", "readback", v, 16'h02A1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_cfg_rw();
    // reset timing: WS=31, 16-bit, gap
    run_access(32'h0300_0010, 0, 0, 31, 2, 1, 1, 0, 0, 0, "boot read");
    // WS=0 32-bit, no gap
    cfg_write(6, mk(0, 2, 1, 0));
    run_access(32'h0600_0104, 0, 0, 0, 4, 0, 1, 0, 0, 0, "ws0 read");
    run_access(32'h0600_0108, 1, 32'hCAFE_1234, 0, 4, 0, 1, 0, 0, 0, "ws0 write");
    // 8-bit port
    cfg_write(2, mk(3, 0, 1, 0));
    run_access(32'h0200_0220, 0, 0, 3, 1, 0, 1, 0, 0, 0, "w8 read");
    run_access(32'h0200_0224, 1, 32'h8765_4321, 3, 1, 0, 1, 0, 0, 0, "w8 write");
    // 16-bit with WS=1 and gap (0x2A1)
    run_access(32'h0000_0330, 1, 32'hA5A5_0F0F, 1, 2, 1, 1, 0, 0, 0, "w16 write");
    run_access(32'h0000_0334, 0, 0, 1, 2, 1, 1, 0, 0, 0, "w16 read");
    // write disabled region
    cfg_write(7, mk(2, 2, 0, 0));
    run_access(32'h0700_0040, 1, 32'h1111_2222, 2, 4, 0, 0, 0, 0, 0, "ro write");
    // width code 11 acts as 32-bit
    cfg_write(4, mk(1, 3, 1, 0));
    run_access(32'h0400_0500, 0, 0, 1, 4, 0, 1, 0, 0, 0, "w11 read");
    // request during a busy access is ignored
    cfg_write(5, mk(4, 1, 1, 0));
    run_access(32'h0500_0060, 0, 0, 4, 2, 0, 1, 1, 0, 0, "busy poke");
    // R10: setup write in the same clock as acceptance
    cfg_write(1, mk(2, 2, 1, 0));
    run_access(32'h0100_0080, 0, 0, 2, 4, 0, 1, 0, 1, mk(5, 2, 1, 0), "r10 old setup");
    run_access(32'h0100_0084, 0, 0, 5, 4, 0, 1, 0, 0, 0, "r10 new setup");
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule